// File: doc/BRIEF.md
# Vector Gather-Load Sequencer

This block carries out one gather load into a 128-bit vector register. A start pulse captures a 32-bit scalar base, a vector of per-lane offsets, a per-byte predicate, a per-byte beat-execution mask, the previous destination contents and a load configuration. The block then walks the lanes in ascending order. For each lane it forms an address from the base and that lane's offset, issues one read on a simple request/response memory port, and places the extended result in the lane.

Lanes whose predicate bit is clear are zeroed without a read. Lanes whose beat mask bit is clear are left exactly as they were. A 64-bit mode treats the register as four 32-bit beats that form two doubleword elements. Each beat pair shares the offset of its even beat, and the odd beat reads the next word up. When the last lane is finished, a one-cycle completion pulse and a pulse to advance the predication state are raised together, and the whole destination vector is valid.

Top module: `vgather_seq`

## Requirements
- R1: While reset is asserted and while no load is running, rd_req_o, done_o, pred_adv_o and busy_o are low.
- R2: A start_i pulse while idle captures all inputs. The lane size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) gives 16 / size lanes, which are handled in ascending order. Each lane that is enabled and active issues exactly one read. Its address is base_i plus the zero-extended lane-width offset element, taken modulo 2^32.
- R3: With scaled_i set, the offset is shifted left by the access size code before the add: 0 for a byte, 1 for a halfword, 2 for a word.
- R4: A lane is active when the pred_i bit at its lowest byte position is set. An inactive lane whose beat is enabled issues no read and has all of its bytes written with zero.
- R5: A lane whose beat_i bit at its lowest byte position is clear issues no read. Its destination bytes keep the values captured from vd_i at start.
- R6: rd_size_o carries the access size code (0 byte, 1 halfword, 2 word). Read data is right-aligned in rd_rdata_i, and bits above the access size are ignored. The loaded value is sign-extended when signed_i is set and zero-extended otherwise, and it fills the lane width.
- R7: With dword_i set, the lane and access sizes are forced to 4 bytes over four beats. Beats 2k and 2k+1 both use 32-bit offset element 2k, scaled by 3 when scaled_i is set, and beat 2k+1 adds 4 to the address. Each beat's word lands in its own 32-bit slot, so the low word sits at the lower address.
- R8: A request holds rd_req_o, rd_addr_o and rd_size_o stable until rd_ready_i is sampled high. No new request is made between an accepted request and its rd_rvalid_i.
- R9: One cycle after the final lane completes, done_o and pred_adv_o are high for exactly one cycle. At that point vd_o holds the full result, and it keeps holding it until the next start.
- R10: start_i while busy_o is high is ignored, and input changes after a start is accepted do not affect the running load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_i | input | 32 | Scalar base address |
| offs_i | input | 128 | Offset vector, one element per lane |
| pred_i | input | 16 | Per-byte predicate |
| beat_i | input | 16 | Per-byte beat-execution mask |
| lane_sz_i | input | 2 | Lane size code |
| acc_sz_i | input | 2 | Memory access size code |
| signed_i | input | 1 | Sign-extend narrow loads |
| scaled_i | input | 1 | Scale offsets by the access size |
| dword_i | input | 1 | 64-bit element mode |
| vd_i | input | 128 | Previous destination contents |
| rd_req_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | 32 | Read address |
| rd_size_o | output | 2 | Read size code |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_rdata_i | input | 32 | Read data, right-aligned |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Completion pulse |
| pred_adv_o | output | 1 | Advance-predication pulse |
| vd_o | output | 128 | Destination vector |

## Verification
The hardest case to reach is a single load that mixes all three lane outcomes: one beat skipped, one zeroed and one read, while the memory side is stalling. Skipped lanes only show up as bytes that keep their old value, and in 64-bit mode the odd beat borrows the even beat's offset. The bench therefore fills the destination with a non-zero pattern, uses different offset values in the odd elements, and combines partial predicate and beat masks. It also varies the grant and response delays from one vector to the next. In a separate run it pulses start and changes every input partway through, to show that the captured values are the ones used.

// File: rtl/vgather_pkg.sv
package vgather_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } size_e;

  typedef struct packed {
    size_e lane_sz;
    size_e acc_sz;
    logic  sgn;
    logic  scl;
    logic  dw;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } state_e;
endpackage

// File: rtl/vg_addr_gen.sv
module vg_addr_gen
  import vgather_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  parameter int unsigned AW        = 32,
  localparam int unsigned VEC_W    = VEC_BYTES * 8,
  localparam int unsigned IDX_W    = $clog2(VEC_BYTES)
) (
  input  logic [AW-1:0]    base_i,
  input  logic [VEC_W-1:0] offs_i,
  input  logic [IDX_W-1:0] lane_i,
  input  cfg_t             cfg_i,
  output logic [AW-1:0]    addr_o,
  output size_e            size_o
);
  logic [31:0] off_b, off_h, off_w, off_d, off_sel;
  logic [1:0]  shamt;
  logic [IDX_W-1:0] even_lane;

  assign even_lane = {lane_i[IDX_W-1:1], 1'b0};

  always_comb begin
    off_b = 32'(offs_i[lane_i*8 +: 8]);
    off_h = 32'(offs_i[lane_i*16 +: 16]);
    off_w = offs_i[lane_i*32 +: 32];
    off_d = offs_i[even_lane*32 +: 32];
  end

  always_comb begin
    if (cfg_i.dw) begin
      off_sel = off_d;
      size_o  = SZ_W;
    end else begin
      size_o = cfg_i.acc_sz;
      unique case (cfg_i.lane_sz)
        SZ_B:    off_sel = off_b;
        SZ_H:    off_sel = off_h;
        default: off_sel = off_w;
      endcase
    end
  end

  // doubleword scaling is 3; otherwise by access size
  logic [2:0] sh;
  always_comb begin
    shamt = cfg_i.acc_sz;
    if (!cfg_i.scl)     sh = 3'd0;
    else if (cfg_i.dw)  sh = 3'd3;
    else                sh = {1'b0, shamt};
  end

  logic [AW-1:0] odd_adj;
  assign odd_adj = (cfg_i.dw && lane_i[0]) ? AW'(4) : '0;
  assign addr_o  = base_i + (AW'(off_sel) << sh) + odd_adj;
endmodule

// File: rtl/vg_load_ext.sv
module vg_load_ext
  import vgather_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] raw_i,
  input  size_e         size_i,
  input  logic          sgn_i,
  output logic [DW-1:0] val_o
);
  always_comb begin
    unique case (size_i)
      SZ_B:    val_o = {{(DW-8){sgn_i & raw_i[7]}}, raw_i[7:0]};
      SZ_H:    val_o = {{(DW-16){sgn_i & raw_i[15]}}, raw_i[15:0]};
      default: val_o = raw_i;
    endcase
  end
endmodule

// File: rtl/vg_lane_ctrl.sv
module vg_lane_ctrl
  import vgather_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned IDX_W    = $clog2(VEC_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           lsz_log2_i,
  input  logic [VEC_BYTES-1:0] pred_i,
  input  logic [VEC_BYTES-1:0] beat_i,
  input  logic                 rd_ready_i,
  input  logic                 rd_rvalid_i,
  output logic [IDX_W-1:0]     lane_o,
  output logic [IDX_W-1:0]     pos_o,
  output logic                 accept_o,
  output logic                 busy_o,
  output logic                 req_o,
  output logic                 wr_zero_o,
  output logic                 wr_load_o,
  output logic                 done_o,
  output logic                 adv_o
);
  state_e state_q, state_d;
  logic [IDX_W-1:0] lane_q, lane_d, last_lane;
  logic step;

  assign pos_o     = lane_q << lsz_log2_i;
  assign last_lane = IDX_W'((VEC_BYTES >> lsz_log2_i) - 1);
  assign lane_o    = lane_q;

  always_comb begin
    state_d   = state_q;
    lane_d    = lane_q;
    step      = 1'b0;
    accept_o  = 1'b0;
    req_o     = 1'b0;
    wr_zero_o = 1'b0;
    wr_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        accept_o = 1'b1;
        lane_d   = '0;
        state_d  = ST_EVAL;
      end
      ST_EVAL: begin
        if (!beat_i[pos_o]) begin
          step = 1'b1;
        end else if (!pred_i[pos_o]) begin
          wr_zero_o = 1'b1;
          step      = 1'b1;
        end else begin
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        req_o = 1'b1;
        if (rd_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: if (rd_rvalid_i) begin
        wr_load_o = 1'b1;
        step      = 1'b1;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (step) begin
      if (lane_q == last_lane) begin
        state_d = ST_FIN;
      end else begin
        lane_d  = lane_q + 1'b1;
        state_d = ST_EVAL;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign adv_o  = (state_q == ST_FIN);
endmodule

// File: rtl/vgather_seq.sv
module vgather_seq
  import vgather_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  localparam int unsigned VEC_W    = VEC_BYTES * 8,
  localparam int unsigned IDX_W    = $clog2(VEC_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [AW-1:0]        base_i,
  input  logic [VEC_W-1:0]     offs_i,
  input  logic [VEC_BYTES-1:0] pred_i,
  input  logic [VEC_BYTES-1:0] beat_i,
  input  logic [1:0]           lane_sz_i,
  input  logic [1:0]           acc_sz_i,
  input  logic                 signed_i,
  input  logic                 scaled_i,
  input  logic                 dword_i,
  input  logic [VEC_W-1:0]     vd_i,
  output logic                 rd_req_o,
  input  logic                 rd_ready_i,
  output logic [AW-1:0]        rd_addr_o,
  output logic [1:0]           rd_size_o,
  input  logic                 rd_rvalid_i,
  input  logic [DW-1:0]        rd_rdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 pred_adv_o,
  output logic [VEC_W-1:0]     vd_o
);
  logic [AW-1:0]        base_q;
  logic [VEC_W-1:0]     offs_q, vd_q;
  logic [VEC_BYTES-1:0] pred_q, beat_q;
  cfg_t                 cfg_q;

  logic [IDX_W-1:0] lane, pos;
  logic accept, wr_zero, wr_load;
  logic [1:0] lsz_log2;
  size_e size;
  logic [DW-1:0] ext_val, wr_val;

  assign lsz_log2 = cfg_q.dw ? 2'd2 : cfg_q.lane_sz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      offs_q <= '0;
      pred_q <= '0;
      beat_q <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      base_q <= base_i;
      offs_q <= offs_i;
      pred_q <= pred_i;
      beat_q <= beat_i;
      cfg_q  <= '{lane_sz: size_e'(lane_sz_i), acc_sz: size_e'(acc_sz_i),
                 sgn: signed_i, scl: scaled_i, dw: dword_i};
    end
  end

  vg_lane_ctrl #(.VEC_BYTES(VEC_BYTES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .lsz_log2_i (lsz_log2),
    .pred_i     (pred_q),
    .beat_i     (beat_q),
    .rd_ready_i (rd_ready_i),
    .rd_rvalid_i(rd_rvalid_i),
    .lane_o     (lane),
    .pos_o      (pos),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .req_o      (rd_req_o),
    .wr_zero_o  (wr_zero),
    .wr_load_o  (wr_load),
    .done_o     (done_o),
    .adv_o      (pred_adv_o)
  );

  vg_addr_gen #(.VEC_BYTES(VEC_BYTES), .AW(AW)) u_addr (
    .base_i(base_q),
    .offs_i(offs_q),
    .lane_i(lane),
    .cfg_i (cfg_q),
    .addr_o(rd_addr_o),
    .size_o(size)
  );

  assign rd_size_o = size;

  vg_load_ext #(.DW(DW)) u_ext (
    .raw_i (rd_rdata_i),
    .size_i(size),
    .sgn_i (cfg_q.sgn),
    .val_o (ext_val)
  );

  assign wr_val = wr_zero ? '0 : ext_val;

  // byte window [lo, hi) of the current lane
  logic [IDX_W:0] win_lo, win_hi;
  assign win_lo = {1'b0, pos};
  assign win_hi = win_lo + ((IDX_W+1)'(1) << lsz_log2);

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    logic       hit;
    logic [1:0] sel;
    assign hit = ((IDX_W+1)'(b) >= win_lo) && ((IDX_W+1)'(b) < win_hi);
    assign sel = 2'((IDX_W+1)'(b) - win_lo);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        vd_q[b*8 +: 8] <= '0;
      else if (accept)                    vd_q[b*8 +: 8] <= vd_i[b*8 +: 8];
      else if (hit && (wr_zero || wr_load)) vd_q[b*8 +: 8] <= wr_val[sel*8 +: 8];
    end
  end

  assign vd_o = vd_q;
endmodule

// File: rtl/vgather_seq_chk.sv
module vgather_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          pred_adv_o,
  input logic          rd_req_o,
  input logic          rd_ready_i,
  input logic [AW-1:0] rd_addr_o,
  input logic [1:0]    rd_size_o,
  input logic          rd_rvalid_i
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (rd_req_o && rd_ready_i)  pend_q <= 1'b1;
    else if (rd_rvalid_i)             pend_q <= 1'b0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_req_o && !done_o && !pred_adv_o));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o) && $stable(rd_size_o)));

  assert_one_outstanding_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !rd_req_o);

  assert_size_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_size_o != 2'd3));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pred_adv_o && !rd_req_o && !pend_q));

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind vgather_seq vgather_seq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pred_adv_o (pred_adv_o),
  .rd_req_o   (rd_req_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .rd_size_o  (rd_size_o),
  .rd_rvalid_i(rd_rvalid_i)
);

// File: tb/vgather_seq_bench.sv
module vgather_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [31:0]  base;
    logic [127:0] offs;
    logic [15:0]  pred;
    logic [15:0]  beat;
    logic [1:0]   lsz;
    logic [1:0]   asz;
    logic         sgn;
    logic         scl;
    logic         dw;
    logic [127:0] init;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{32'h0000_1000, 128'h1F1E1D1C_1B1A1918_17161514_13121110, 16'hFFFF, 16'hFFFF,
      2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 128'h0},
    '{32'h0000_2003, 128'h0070_0061_0052_0043_0034_0025_0016_0007, 16'hFFFF, 16'hFFFF,
      2'd1, 2'd0, 1'b1, 1'b0, 1'b0, {16{8'hA5}}},
    '{32'h0001_0000, 128'h00000030_00000021_00000012_00000003, 16'hFFFF, 16'hFFFF,
      2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 128'h0},
    '{32'h0000_4000, 128'h0007_0006_0005_0004_0003_0002_0001_0000, 16'h0F33, 16'hFFFF,
      2'd1, 2'd1, 1'b1, 1'b1, 1'b0, {16{8'h11}}},
    '{32'h0000_5000, 128'h000000C0_00000080_00000040_00000000, 16'hFFFF, 16'h0F0F,
      2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF},
    '{32'h0000_6000, 128'h77777777_00000010_55555555_00000008, 16'hFFFF, 16'hFFFF,
      2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 128'h0},
    '{32'h0000_7000, 128'hAAAAAAAA_00000003_BBBBBBBB_00000002, 16'h0FFF, 16'hFFF0,
      2'd2, 2'd2, 1'b0, 1'b1, 1'b1, {16{8'hFF}}},
    '{32'hFFFF_FFF0, 128'h00000040_00000020_00000010_00000008, 16'hFFFF, 16'hFFFF,
      2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 128'h0},
    '{32'h0000_0000, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 16'hFFFF, 16'h0000,
      2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 128'h01234567_89ABCDEF_FEDCBA98_76543210},
    '{32'h0000_8000, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 16'hAAAA, 16'hFFFF,
      2'd0, 2'd0, 1'b1, 1'b1, 1'b0, {16{8'h3C}}}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";
      1: return "R6";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R7";
      6: return "R7";
      7: return "R2";
      8: return "R5";
      default: return "R3";
    endcase
  endfunction

  logic clk_i = 1'b0;
  logic rst_ni;
  logic start_i;
  logic [31:0] base_i;
  logic [127:0] offs_i, vd_i, vd_o;
  logic [15:0] pred_i, beat_i;
  logic [1:0] lane_sz_i, acc_sz_i, rd_size_o;
  logic signed_i, scaled_i, dword_i;
  logic rd_req_o, rd_ready_i, rd_rvalid_i;
  logic [31:0] rd_addr_o, rd_rdata_i;
  logic busy_o, done_o, pred_adv_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vgather_seq u_vgather_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .offs_i(offs_i), .pred_i(pred_i), .beat_i(beat_i), .lane_sz_i(lane_sz_i),
    .acc_sz_i(acc_sz_i), .signed_i(signed_i), .scaled_i(scaled_i), .dword_i(dword_i),
    .vd_i(vd_i), .rd_req_o(rd_req_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_size_o(rd_size_o), .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .pred_adv_o(pred_adv_o), .vd_o(vd_o)
  );

  int n_chk = 0, n_fail = 0;
  int stall_cyc = 0, resp_dly = 0;
  int n_seen = 0, n_done = 0, n_adv = 0, n_unstable = 0;
  logic [31:0] seen_addr [32];
  logic [1:0]  seen_sz [32];
  logic [127:0] vd_at_done;
  logic [127:0] exp_vd;
  int exp_n;
  logic [31:0] exp_addr [16];
  logic [1:0]  exp_sz [16];

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h96;
  endfunction

  // full bus word: bytes above the access size carry garbage
  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {mem_byte(a + 32'd3), mem_byte(a + 32'd2), mem_byte(a + 32'd1), mem_byte(a)};
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input vec_t v);
    int lszl, lsz, pos, sh, asz;
    logic [31:0] off, addr, raw, ext;
    exp_vd = v.init;
    exp_n  = 0;
    lszl = v.dw ? 2 : int'(v.lsz);
    lsz  = 1 << lszl;
    for (int e = 0; e < 16 / lsz; e++) begin
      pos = e * lsz;
      if (!v.beat[pos]) continue;
      if (!v.pred[pos]) begin
        for (int k = 0; k < lsz; k++) exp_vd[(pos+k)*8 +: 8] = 8'h00;
        continue;
      end
      if (v.dw) begin
        asz  = 2;
        off  = v.offs[(e & ~1)*32 +: 32];
        sh   = v.scl ? 3 : 0;
        addr = v.base + (off << sh) + 32'((e & 1) * 4);
      end else begin
        asz = int'(v.asz);
        off = '0;
        for (int k = 0; k < lsz; k++) off[k*8 +: 8] = v.offs[(pos+k)*8 +: 8];
        sh   = v.scl ? asz : 0;
        addr = v.base + (off << sh);
      end
      exp_addr[exp_n] = addr;
      exp_sz[exp_n]   = 2'(asz);
      exp_n++;
      raw = mem_word(addr);
      case (asz)
        0: ext = v.sgn ? {{24{raw[7]}}, raw[7:0]} : {24'h0, raw[7:0]};
        1: ext = v.sgn ? {{16{raw[15]}}, raw[15:0]} : {16'h0, raw[15:0]};
        default: ext = raw;
      endcase
      for (int k = 0; k < lsz; k++) exp_vd[(pos+k)*8 +: 8] = ext[k*8 +: 8];
    end
  endtask

  // memory responder
  initial begin
    logic [31:0] a0;
    rd_ready_i  = 1'b0;
    rd_rvalid_i = 1'b0;
    rd_rdata_i  = '0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && rd_req_o) begin
        a0 = rd_addr_o;
        repeat (stall_cyc) @(negedge clk_i);
        if (rd_addr_o !== a0 || !rd_req_o) n_unstable++;
        if (n_seen < 32) begin
          seen_addr[n_seen] = rd_addr_o;
          seen_sz[n_seen]   = rd_size_o;
        end
        n_seen++;
        rd_ready_i = 1'b1;
        @(negedge clk_i);
        rd_ready_i = 1'b0;
        repeat (resp_dly) @(negedge clk_i);
        rd_rdata_i  = mem_word(seen_addr[(n_seen-1) % 32]);
        rd_rvalid_i = 1'b1;
        @(negedge clk_i);
        rd_rvalid_i = 1'b0;
        rd_rdata_i  = 32'hBAD0_BAD0;
      end
    end
  end

  // done / advance monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) begin
        n_done++;
        vd_at_done = vd_o;
      end
      if (pred_adv_o) n_adv++;
    end
  end

  task automatic drive(input vec_t v);
    base_i    = v.base;
    offs_i    = v.offs;
    pred_i    = v.pred;
    beat_i    = v.beat;
    lane_sz_i = v.lsz;
    acc_sz_i  = v.asz;
    signed_i  = v.sgn;
    scaled_i  = v.scl;
    dword_i   = v.dw;
    vd_i      = v.init;
  endtask

  task automatic run_vec(input vec_t v, input string tag, input int stall, input int dly,
                         input bit poke);
    int t;
    model(v);
    stall_cyc = stall;
    resp_dly  = dly;
    n_seen = 0; n_done = 0; n_adv = 0; n_unstable = 0;
    @(negedge clk_i);
    drive(v);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk_i);
      drive('{32'h5555_0000, {4{32'h0000_0100}}, 16'h0000, 16'hFFFF, 2'd0, 2'd0,
              1'b1, 1'b1, 1'b1, {16{8'hEE}}});
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    t = 0;
    while (n_done == 0 && t < 2000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (2) @(negedge clk_i);
    chk("R9", {tag, " done pulse count"}, 128'(n_done), 128'd1);
    chk("R9", {tag, " advance pulse count"}, 128'(n_adv), 128'd1);
    chk(tag, "vector at done", vd_at_done, exp_vd);
    chk("R9", {tag, " vector held after done"}, vd_o, exp_vd);
    chk(tag, "read count", 128'(n_seen), 128'(exp_n));
    for (int i = 0; i < exp_n && i < n_seen; i++) begin
      chk(tag, $sformatf("read %0d address", i), 128'(seen_addr[i]), 128'(exp_addr[i]));
      chk("R6", $sformatf("%s read %0d size", tag, i), 128'(seen_sz[i]), 128'(exp_sz[i]));
    end
    chk("R8", {tag, " request stable under stall"}, 128'(n_unstable), 128'd0);
    chk("R1", {tag, " idle after done"}, 128'({busy_o, rd_req_o, done_o}), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    drive(TBL[0]);
    repeat (3) @(negedge clk_i);
    chk("R1", "outputs in reset",
        128'({busy_o, done_o, pred_adv_o, rd_req_o}), 128'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1", "outputs idle after reset",
        128'({busy_o, done_o, pred_adv_o, rd_req_o}), 128'd0);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(TBL[i], tag_of(i), i % 4, i % 3, 1'b0);
    end

    // R8: long grant stall and slow response
    run_vec(TBL[3], "R8", 7, 4, 1'b0);
    // R10: start and new inputs while busy are ignored
    run_vec(TBL[2], "R10", 3, 2, 1'b1);
    run_vec(TBL[6], "R10", 2, 1, 1'b1);
    // R4: all lanes predicated off, no reads, all zero
    run_vec('{32'h0000_9000, 128'h0, 16'h0000, 16'hFFFF, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0,
              {16{8'h77}}}, "R4", 0, 0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule